// File: doc/BRIEF.md
# Quad Depth Test Unit

This block runs the depth test on one 2x2 quad of fragments, handled as four parallel lanes. Each lane brings a single-precision fragment depth in the range [0,1], an alive bit, and the 32-bit packed depth/stencil word read from the depth tile. The block turns the fragment depth into a 24-bit unsigned value and pulls the stored 24-bit depth out of the packed word. It then compares the two values under one of eight compare functions. It returns the updated alive mask, the per-lane compare result, and the repacked depth/stencil words for write-back.

The stencil byte of each word is kept as it is. A lane's depth field is replaced only when depth writes are enabled and the lane is still alive after the test. A separate write-back flag tells the tile store whether the words need to be written at all. Quads enter and leave through valid/ready handshakes. The block holds two register stages: conversion and extraction in the first, compare and repack in the second.

Top module: `quad_depth_test`

## Requirements
- R1: Fragment depth converts to floor(f * (2^24-1)) for 0 <= f < 1. A positive value at or above 1.0, including +infinity, gives 0xFFFFFF. A value with the sign bit set (including -0), a NaN, or a zero exponent field gives 0.
- R2: With in_fmt=0 the stored depth is word bits [23:0] and the stencil is bits [31:24]. With in_fmt=1 the depth is bits [31:8] and the stencil is bits [7:0].
- R3: Function codes are 0 NEVER, 1 LESS, 2 EQUAL, 3 LEQUAL, 4 GREATER, 5 NOTEQUAL, 6 GEQUAL, 7 ALWAYS. out_cmp per lane is the raw compare of fragment depth F against stored depth S: F==S for EQUAL and NOTEQUAL, F>S for GREATER and LEQUAL, F<S for LESS and GEQUAL.
- R4: For LESS, EQUAL and GREATER, out_alive = in_alive AND raw compare. No lane is ever alive at the output unless it was alive at the input.
- R5: For NOTEQUAL, LEQUAL and GEQUAL, out_alive = in_alive AND NOT raw compare.
- R6: NEVER drives out_alive and out_cmp to all zeros.
- R7: ALWAYS drives out_cmp to all ones and passes in_alive through unchanged.
- R8: With in_zwen=1, a lane whose out_alive bit is set gets the fragment depth in its depth field. Every other lane, and every lane when in_zwen=0, keeps its stored word. The stencil field is never changed.
- R9: out_wb = in_zwen OR (in_swm_front != 0) OR (in_swm_back != 0).
- R10: A quad accepted at a rising edge (in_valid and in_ready high) appears with out_valid high after the next rising edge when the output is free. While out_valid is high and out_ready is low, all outputs hold steady. Quads leave in the order they entered.
- R11: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input quad valid |
| in_ready | output | 1 | Block can take a quad |
| in_zf | input | 128 | Four float fragment depths, lane i at [32i+31:32i] |
| in_alive | input | 4 | Alive mask, bit i for lane i |
| in_zs | input | 128 | Four stored depth/stencil words |
| in_func | input | 3 | Compare function code |
| in_zwen | input | 1 | Depth write enable |
| in_swm_front | input | 8 | Front stencil write mask |
| in_swm_back | input | 8 | Back stencil write mask |
| in_fmt | input | 1 | Word layout: 0 stencil high, 1 stencil low |
| out_valid | output | 1 | Output quad valid |
| out_ready | input | 1 | Consumer takes the output quad |
| out_alive | output | 4 | Updated alive mask |
| out_cmp | output | 4 | Per-lane compare result |
| out_zs | output | 128 | Repacked depth/stencil words |
| out_wb | output | 1 | Words must be written back |

## Verification
The assertions assume that a reset is applied before any traffic and that out_ready may change in any cycle. They also assume every 3-bit function code is legal, so no input state is excluded. The stage checks compare each output against the stage-one register contents one edge earlier, so they assume those contents stay unchanged while stage two is stalled. The bench keeps within these limits: once a quad is presented, it holds in_valid and all quad fields steady until acceptance, and it toggles out_ready at random to create stalls.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int WW = 32;          // packed depth/stencil word
  localparam int ZW = 24;          // depth field
  localparam int SW = WW - ZW;     // stencil field
  localparam int FW = 32;          // float word

  typedef enum logic [2:0] {
    ZF_NEVER    = 3'd0,
    ZF_LESS     = 3'd1,
    ZF_EQUAL    = 3'd2,
    ZF_LEQUAL   = 3'd3,
    ZF_GREATER  = 3'd4,
    ZF_NOTEQUAL = 3'd5,
    ZF_GEQUAL   = 3'd6,
    ZF_ALWAYS   = 3'd7
  } zfunc_e;

  // float in [0,1] -> floor(f * (2^ZW - 1)), exact integer product
  function automatic logic [ZW-1:0] float_to_z(input logic [FW-1:0] f);
    logic [7:0]        ex;
    logic [2*ZW-1:0]   prod;
    int                sh;
    ex = f[30:23];
    if (f[31] || ex == 8'd0 || (ex == 8'hFF && f[22:0] != '0))
      return '0;
    if (ex >= 8'd127)
      return '1;
    prod = (2*ZW)'({1'b1, f[22:0]}) * (2*ZW)'({ZW{1'b1}});
    sh   = 150 - int'(ex);
    if (sh >= 2*ZW)
      return '0;
    return ZW'(prod >> sh);
  endfunction

  function automatic logic [ZW-1:0] word_depth(input logic [WW-1:0] w, input logic fmt);
    return fmt ? w[WW-1:SW] : w[ZW-1:0];
  endfunction

  function automatic logic [WW-1:0] word_pack(input logic [WW-1:0] w,
                                              input logic [ZW-1:0] z,
                                              input logic fmt);
    return fmt ? {z, w[SW-1:0]} : {w[WW-1:ZW], z};
  endfunction
endpackage

// File: rtl/qdt_front.sv
module qdt_front
  import qdt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*FW-1:0]        zf_i,
  input  logic [LANES*WW-1:0]        zs_i,
  input  logic                       fmt_i,
  output logic [LANES-1:0][ZW-1:0]   fz_o,
  output logic [LANES-1:0][ZW-1:0]   oz_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign fz_o[g] = float_to_z(zf_i[g*FW +: FW]);
    assign oz_o[g] = word_depth(zs_i[g*WW +: WW], fmt_i);
  end
endmodule

// File: rtl/qdt_lane.sv
module qdt_lane
  import qdt_pkg::*;
(
  input  logic [ZW-1:0] fz_i,
  input  logic [ZW-1:0] oz_i,
  input  logic [WW-1:0] word_i,
  input  logic          alive_i,
  input  zfunc_e        func_i,
  input  logic          zwen_i,
  input  logic          fmt_i,
  output logic          alive_o,
  output logic          cmp_o,
  output logic [WW-1:0] word_o
);
  logic eq_w, gt_w, lt_w, raw_w;
  logic [ZW-1:0] nz_w;

  assign eq_w = (fz_i == oz_i);
  assign gt_w = (fz_i >  oz_i);
  assign lt_w = (fz_i <  oz_i);

  always_comb begin
    raw_w   = 1'b0;
    cmp_o   = 1'b0;
    alive_o = 1'b0;
    unique case (func_i)
      ZF_EQUAL, ZF_NOTEQUAL:  raw_w = eq_w;
      ZF_GREATER, ZF_LEQUAL:  raw_w = gt_w;
      ZF_LESS, ZF_GEQUAL:     raw_w = lt_w;
      default:                raw_w = 1'b0;
    endcase
    unique case (func_i)
      ZF_NEVER: begin
        cmp_o   = 1'b0;
        alive_o = 1'b0;
      end
      ZF_ALWAYS: begin
        cmp_o   = 1'b1;
        alive_o = alive_i;
      end
      ZF_EQUAL, ZF_GREATER, ZF_LESS: begin
        cmp_o   = raw_w;
        alive_o = alive_i & raw_w;
      end
      default: begin
        cmp_o   = raw_w;
        alive_o = alive_i & ~raw_w;
      end
    endcase
  end

  assign nz_w   = (zwen_i && alive_o) ? fz_i : oz_i;
  assign word_o = word_pack(word_i, nz_w, fmt_i);
endmodule

// File: rtl/quad_depth_test.sv
module quad_depth_test
  import qdt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [LANES*FW-1:0]  in_zf,
  input  logic [LANES-1:0]     in_alive,
  input  logic [LANES*WW-1:0]  in_zs,
  input  logic [2:0]           in_func,
  input  logic                 in_zwen,
  input  logic [SW-1:0]        in_swm_front,
  input  logic [SW-1:0]        in_swm_back,
  input  logic                 in_fmt,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [LANES-1:0]     out_alive,
  output logic [LANES-1:0]     out_cmp,
  output logic [LANES*WW-1:0]  out_zs,
  output logic                 out_wb
);
  // named pipeline events
  logic st1_adv, st2_adv;

  logic [LANES-1:0][ZW-1:0] c_fz, c_oz;

  logic                     s1_v;
  logic [LANES-1:0][ZW-1:0] s1_fz, s1_oz;
  logic [LANES*WW-1:0]      s1_zs;
  logic [LANES-1:0]         s1_alive;
  zfunc_e                   s1_func;
  logic                     s1_zwen, s1_wb, s1_fmt;

  logic [LANES-1:0]         n_alive, n_cmp;
  logic [LANES-1:0][WW-1:0] n_word;

  assign st2_adv  = s1_v && (!out_valid || out_ready);
  assign in_ready = !s1_v || st2_adv;
  assign st1_adv  = in_valid && in_ready;

  qdt_front #(.LANES(LANES)) u_front (
    .zf_i  (in_zf),
    .zs_i  (in_zs),
    .fmt_i (in_fmt),
    .fz_o  (c_fz),
    .oz_o  (c_oz)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_fz    <= '0;
      s1_oz    <= '0;
      s1_zs    <= '0;
      s1_alive <= '0;
      s1_func  <= ZF_NEVER;
      s1_zwen  <= 1'b0;
      s1_wb    <= 1'b0;
      s1_fmt   <= 1'b0;
    end else begin
      if (st1_adv) begin
        s1_v     <= 1'b1;
        s1_fz    <= c_fz;
        s1_oz    <= c_oz;
        s1_zs    <= in_zs;
        s1_alive <= in_alive;
        s1_func  <= zfunc_e'(in_func);
        s1_zwen  <= in_zwen;
        s1_wb    <= in_zwen | (|in_swm_front) | (|in_swm_back);
        s1_fmt   <= in_fmt;
      end else if (st2_adv) begin
        s1_v <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qdt_lane u_lane (
      .fz_i    (s1_fz[g]),
      .oz_i    (s1_oz[g]),
      .word_i  (s1_zs[g*WW +: WW]),
      .alive_i (s1_alive[g]),
      .func_i  (s1_func),
      .zwen_i  (s1_zwen),
      .fmt_i   (s1_fmt),
      .alive_o (n_alive[g]),
      .cmp_o   (n_cmp[g]),
      .word_o  (n_word[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_alive <= '0;
      out_cmp   <= '0;
      out_zs    <= '0;
      out_wb    <= 1'b0;
    end else if (st2_adv) begin
      out_valid <= 1'b1;
      out_alive <= n_alive;
      out_cmp   <= n_cmp;
      out_zs    <= n_word;
      out_wb    <= s1_wb;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/qdt_chk.sv
module qdt_chk
  import qdt_pkg::*;
#(
  parameter int LANES = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                st1_adv,
  input logic                st2_adv,
  input logic                s1_v,
  input logic [2:0]          s1_func,
  input logic [LANES-1:0]    s1_alive,
  input logic [LANES*WW-1:0] s1_zs,
  input logic                s1_fmt,
  input logic                s1_zwen,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES-1:0]    out_alive,
  input logic [LANES-1:0]    out_cmp,
  input logic [LANES*WW-1:0] out_zs,
  input logic                out_wb
);
  logic [LANES*WW-1:0] smask_q;

  function automatic logic [LANES*WW-1:0] dead_lanes(input logic [LANES-1:0] a);
    logic [LANES*WW-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (!a[i]) m[i*WW +: WW] = '1;
    return m;
  endfunction

  function automatic logic [LANES*WW-1:0] sten_bits(input logic fmt);
    logic [LANES*WW-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      m[i*WW +: WW] = fmt ? WW'({SW{1'b1}}) : {{SW{1'b1}}, {ZW{1'b0}}};
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) smask_q <= '0;
    else if (st2_adv) smask_q <= sten_bits(s1_fmt);
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_zs) && $stable(out_alive)
                                && $stable(out_cmp) && $stable(out_wb));

  p_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st1_adv |=> s1_v);

  p_never_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st2_adv && s1_func == ZF_NEVER |=> out_alive == '0 && out_cmp == '0);

  p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st2_adv && s1_func == ZF_ALWAYS |=> out_cmp == '1 && out_alive == $past(s1_alive));

  p_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st2_adv |=> (out_alive & ~$past(s1_alive)) == '0);

  p_dead_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st2_adv |=> ((out_zs ^ $past(s1_zs)) & dead_lanes(out_alive)) == '0);

  p_sten_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st2_adv |=> ((out_zs ^ $past(s1_zs)) & smask_q) == '0);

  p_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st2_adv && !s1_zwen |=> out_zs == $past(s1_zs));
endmodule

bind quad_depth_test qdt_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st1_adv   (st1_adv),
  .st2_adv   (st2_adv),
  .s1_v      (s1_v),
  .s1_func   (s1_func),
  .s1_alive  (s1_alive),
  .s1_zs     (s1_zs),
  .s1_fmt    (s1_fmt),
  .s1_zwen   (s1_zwen),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_alive (out_alive),
  .out_cmp   (out_cmp),
  .out_zs    (out_zs),
  .out_wb    (out_wb)
);

// File: tb/sim_quad_depth_test.sv
module sim_quad_depth_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [127:0] in_zf = '0;
  logic [3:0]   in_alive = '0;
  logic [127:0] in_zs = '0;
  logic [2:0]   in_func = '0;
  logic         in_zwen = 1'b0;
  logic [7:0]   in_swm_front = '0;
  logic [7:0]   in_swm_back = '0;
  logic         in_fmt = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [3:0]   out_alive, out_cmp;
  logic [127:0] out_zs;
  logic         out_wb;

  int checks = 0;
  int errors = 0;

  // {func, wb, cmp, alive, zs}
  logic [139:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_depth_test u0 (.*);

  function automatic int unsigned to_z(input logic [31:0] f);
    int e;
    real v;
    e = int'(f[30:23]);
    if (f[31]) return 0;
    if (e == 255) return (f[22:0] != 0) ? 0 : 32'hFFFFFF;
    if (e == 0) return 0;
    if (e >= 127) return 32'hFFFFFF;
    v = (8388608.0 + real'(f[22:0])) * 16777215.0 / (2.0 ** (150 - e));
    return $rtoi(v);
  endfunction

  function automatic logic [139:0] model(input logic [127:0] zf, input logic [3:0] al,
      input logic [127:0] zs, input logic [2:0] fn, input logic zw,
      input logic [7:0] sf, input logic [7:0] sb, input logic fmt);
    logic [127:0] nzs;
    logic [3:0] na, nc;
    nzs = zs;
    for (int i = 0; i < NQ; i++) begin
      int unsigned f, s;
      logic pass, raw;
      logic [31:0] w;
      w = zs[i*32 +: 32];
      f = to_z(zf[i*32 +: 32]);
      s = fmt ? int'(w[31:8]) : int'(w[23:0]);
      case (fn)
        3'd1: begin pass = f < s;  raw = f < s;  end
        3'd2: begin pass = f == s; raw = f == s; end
        3'd3: begin pass = f <= s; raw = f > s;  end
        3'd4: begin pass = f > s;  raw = f > s;  end
        3'd5: begin pass = f != s; raw = f == s; end
        3'd6: begin pass = f >= s; raw = f < s;  end
        3'd7: begin pass = 1'b1;   raw = 1'b1;   end
        default: begin pass = 1'b0; raw = 1'b0;  end
      endcase
      na[i] = al[i] & pass;
      nc[i] = raw;
      if (zw && na[i]) begin
        if (fmt) w[31:8] = f[23:0];
        else     w[23:0] = f[23:0];
      end
      nzs[i*32 +: 32] = w;
    end
    return {fn, zw | (sf != 0) | (sb != 0), nc, na, nzs};
  endfunction

  function automatic string alive_tag(input logic [2:0] fn);
    case (fn)
      3'd0: return "R6";
      3'd7: return "R7";
      3'd1, 3'd2, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rand_float();
    int k;
    k = int'($urandom % 10);
    if (k == 0) return $urandom;
    if (k == 1) begin
      case ($urandom % 6)
        0: return 32'h0000_0000;
        1: return 32'h3F80_0000;
        2: return 32'hBF00_0000;
        3: return 32'h7FC0_0000;
        4: return 32'h7F80_0000;
        default: return 32'h3F7F_FFFF;
      endcase
    end
    return {1'b0, 8'(110 + ($urandom % 17)), 23'($urandom)};
  endfunction

  task automatic gen_quad();
    in_zf = {rand_float(), rand_float(), rand_float(), rand_float()};
    in_fmt = 1'($urandom);
    for (int i = 0; i < NQ; i++) begin
      logic [31:0] w;
      int unsigned z;
      w = $urandom;
      z = to_z(in_zf[i*32 +: 32]);
      if ($urandom % 3 == 0) begin
        if (in_fmt) w[31:8] = z[23:0];
        else        w[23:0] = z[23:0];
      end
      in_zs[i*32 +: 32] = w;
    end
    in_alive = 4'($urandom);
    in_func = 3'($urandom);
    in_zwen = 1'($urandom);
    in_swm_front = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
    in_swm_back  = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
  endtask

  task automatic compare_out(input logic [139:0] e, input string ztag);
    chk(out_alive == e[131:128], alive_tag(e[139:137]), 128'(out_alive), 128'(e[131:128]));
    chk(out_cmp == e[135:132], "R3", 128'(out_cmp), 128'(e[135:132]));
    chk(out_zs == e[127:0], ztag, out_zs, e[127:0]);
    chk(out_wb == e[136], "R9", 128'(out_wb), 128'(e[136]));
  endtask

  // one quad with a free output: checks the two-stage timing too (R10)
  task automatic directed(input logic [127:0] zf, input logic [3:0] al, input logic [127:0] zs,
      input logic [2:0] fn, input logic zw, input logic fmt, input string ztag);
    logic [139:0] e;
    @(negedge clk);
    in_zf = zf; in_alive = al; in_zs = zs; in_func = fn; in_zwen = zw;
    in_swm_front = 8'h00; in_swm_back = 8'h00; in_fmt = fmt;
    in_valid = 1'b1; out_ready = 1'b1;
    e = model(zf, al, zs, fn, zw, 8'h00, 8'h00, fmt);
    #1;
    chk(in_ready == 1'b1, "R10", 128'(in_ready), 128'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R10", 128'(out_valid), 128'(0));
    @(negedge clk);
    chk(out_valid == 1'b1, "R10", 128'(out_valid), 128'(1));
    compare_out(e, ztag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [127:0] held;
    bit pend;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid == 1'b0, "R11", 128'(out_valid), 128'(0));
    chk(in_ready == 1'b1, "R11", 128'(in_ready), 128'(1));
    rst_n = 1'b1;

    // R1 conversion corners, stencil-high layout
    directed({32'h3F00_0000, 32'h3F80_0000, 32'h0000_0000, 32'h3380_0000},
             4'hF, {32'hAA00_0001, 32'hBB00_0002, 32'hCC00_0003, 32'hDD00_0004},
             3'd7, 1'b1, 1'b0, "R1");
    chk(out_zs[127:96] == 32'hAA7F_FFFF, "R1", 128'(out_zs[127:96]), 128'(32'hAA7F_FFFF));
    chk(out_zs[95:64]  == 32'hBBFF_FFFF, "R1", 128'(out_zs[95:64]), 128'(32'hBBFF_FFFF));
    directed({32'hBF00_0000, 32'h7FC0_0000, 32'h7F80_0000, 32'h8000_0000},
             4'hF, {32'h1100_0005, 32'h2200_0006, 32'h3300_0007, 32'h4400_0008},
             3'd7, 1'b1, 1'b0, "R1");
    // R2 stencil-low layout
    directed({32'h3F00_0000, 32'h3F80_0000, 32'h0000_0000, 32'h3E80_0000},
             4'b1010, {32'h1234_5611, 32'h0000_0022, 32'hFFFF_FF33, 32'h0000_0144},
             3'd7, 1'b1, 1'b1, "R2");
    chk(out_zs[127:96] == 32'h7FFF_FF11, "R2", 128'(out_zs[127:96]), 128'(32'h7FFF_FF11));
    chk(out_zs[95:64] == 32'h0000_0022, "R2", 128'(out_zs[95:64]), 128'(32'h0000_0022));
    // R6 NEVER, R7 ALWAYS with writes off, R5 LEQUAL on equal values
    directed({4{32'h3F00_0000}}, 4'hF, {4{32'h007F_FFFF}}, 3'd0, 1'b1, 1'b0, "R6");
    directed({4{32'h3F00_0000}}, 4'h5, {4{32'h007F_FFFF}}, 3'd7, 1'b0, 1'b0, "R7");
    directed({4{32'h3F00_0000}}, 4'hF, {32'h007F_FFFF, 32'h007F_FFFE, 32'h0080_0000, 32'h0000_0000},
             3'd3, 1'b1, 1'b0, "R5");
    directed({4{32'h3F00_0000}}, 4'hF, {32'h007F_FFFF, 32'h007F_FFFE, 32'h0080_0000, 32'h0000_0000},
             3'd2, 1'b1, 1'b0, "R4");

    // R10 hold under back-pressure
    @(negedge clk);
    gen_quad();
    in_valid = 1'b1; out_ready = 1'b0;
    expq.push_back(model(in_zf, in_alive, in_zs, in_func, in_zwen, in_swm_front, in_swm_back, in_fmt));
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    held = out_zs;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1 && out_zs == held, "R10", out_zs, held);
    out_ready = 1'b1;
    compare_out(expq.pop_front(), "R8");

    // random traffic with random back-pressure (R3..R10)
    pend = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (!pend) begin
        if ($urandom % 4 != 0) begin
          gen_quad();
          in_valid = 1'b1;
          pend = 1'b1;
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, "R10", 128'(1), 128'(0));
        else compare_out(expq.pop_front(), "R8");
      end
      if (in_valid && in_ready) begin
        expq.push_back(model(in_zf, in_alive, in_zs, in_func, in_zwen, in_swm_front, in_swm_back, in_fmt));
        pend = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    for (int n = 0; n < 10 && expq.size() != 0; n++) begin
      #1;
      if (out_valid) compare_out(expq.pop_front(), "R8");
      @(negedge clk);
    end
    chk(expq.size() == 0, "R10", 128'(expq.size()), 128'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule